// File: doc/BRIEF.md
# Low-Power Wait/Stop Clock and Wake Controller

This block runs the processor's entry into, and exit from, its two low-power states. When the core retires a wait or stop instruction it raises a one-cycle request. The controller then turns off the core clock enable and tells the core to clear its interrupt mask. In the wait state the peripheral clock enable stays on. In the stop state it is dropped as well.

While the part is asleep, the controller watches three kinds of wake source: pending interrupts whose local enable is set, a debug break, and reset. An interrupt can wake the part from wait whatever its source. Only sources chosen by a parameter can wake it from stop. On a wake the core clock comes back and the controller gives a one-cycle strobe that starts interrupt stacking. If the wake came from a break, a sticky break stop/wait status bit is set. Software clears that bit by writing zero to it.

The watchdog enable follows a configuration disable input. The watchdog keeps counting through wait and is halted in stop.

Top module: `lpm_wake_ctrl`

## Requirements
- R1: After reset `cpu_clk_en` and `per_clk_en` are 1, and `imask_clr`, `stack_start` and `brk_stopwait` are 0.
- R2: A `wait_req` sampled while running makes `cpu_clk_en` 0 and keeps `per_clk_en` 1 from the next cycle on.
- R3: A `stop_req` sampled while running makes both `cpu_clk_en` and `per_clk_en` 0 from the next cycle on. When both requests arrive in the same cycle, stop wins.
- R4: `imask_clr` is high for exactly one cycle, the cycle after a wait or stop request is accepted.
- R5: In wait, any bit i with `irq_pend[i]` and `irq_en[i]` both 1 restores `cpu_clk_en` in the next cycle. `stack_start` is high for that one cycle only.
- R6: A pending interrupt whose `irq_en` bit is 0 does not wake the part.
- R7: In stop, only sources whose bit is 1 in `STOP_WAKE_MASK` can wake the part. Enabled and pending sources outside the mask are ignored.
- R8: A `break_req` in wait or stop wakes the part and sets `brk_stopwait` in the same cycle that `stack_start` pulses. A `break_req` while running leaves `brk_stopwait` unchanged.
- R9: A cycle with `stat_wr_en` 1 and `stat_wr_data` 0 clears `brk_stopwait`. A write of 1 has no effect. A break wake in the same cycle as a clearing write wins, and the bit ends up 1.
- R10: `cop_en` equals the inverse of `cop_disable` while running and in wait, and is 0 in stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wait_req | input | 1 | Core retired a wait instruction |
| stop_req | input | 1 | Core retired a stop instruction |
| irq_pend | input | N_IRQ | Pending interrupt per source |
| irq_en | input | N_IRQ | Local interrupt enable per source |
| break_req | input | 1 | Debug break request |
| cop_disable | input | 1 | Configuration bit that turns the watchdog off |
| stat_wr_en | input | 1 | Write strobe for the break status bit |
| stat_wr_data | input | 1 | Write data; 0 clears the status bit |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask_clr | output | 1 | One-cycle pulse that clears the core interrupt mask |
| stack_start | output | 1 | One-cycle strobe that starts interrupt stacking |
| brk_stopwait | output | 1 | Sticky flag: a break woke the part |
| cop_en | output | 1 | Watchdog enable |

## Verification
The bench builds the block with `N_IRQ` = 4 and `STOP_WAKE_MASK` = 4'b0100. With these values one bench can drive a stop wake from an allowed source and also try a wake from a source outside the mask. The narrow vector keeps every wait-state wake source easy to reach.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
   typedef enum logic [1:0] {
      LPM_RUN  = 2'd0,
      LPM_WAIT = 2'd1,
      LPM_STOP = 2'd2
   } lpm_state_t;
endpackage

// File: rtl/lpm_wake_detect.sv
module lpm_wake_detect #(
   parameter int unsigned          N_IRQ          = 8,
   parameter logic [N_IRQ-1:0]     STOP_WAKE_MASK = '1
) (
   input  logic [N_IRQ-1:0] irq_pend,
   input  logic [N_IRQ-1:0] irq_en,
   output logic             wake_wait,
   output logic             wake_stop
);
   logic [N_IRQ-1:0] live;
   logic [N_IRQ-1:0] live_stop;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_src
      assign live[i] = irq_pend[i] & irq_en[i];
      if (STOP_WAKE_MASK[i]) begin : g_stop_ok
         assign live_stop[i] = live[i];
      end else begin : g_stop_blk
         assign live_stop[i] = 1'b0;
      end
   end

   assign wake_wait = |live;
   assign wake_stop = |live_stop;
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
   import lpm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wait_req,
   input  logic       stop_req,
   input  logic       wake_wait,
   input  logic       wake_stop,
   input  logic       break_req,
   output lpm_state_t state,
   output logic       imask_clr,
   output logic       stack_start,
   output logic       brk_wake
);
   lpm_state_t nxt;
   logic       enter;
   logic       leave;

   always_comb begin
      nxt = state;
      unique case (state)
         LPM_RUN: begin
            if (stop_req)      nxt = LPM_STOP;
            else if (wait_req) nxt = LPM_WAIT;
         end
         LPM_WAIT: if (break_req || wake_wait) nxt = LPM_RUN;
         LPM_STOP: if (break_req || wake_stop) nxt = LPM_RUN;
         default:  nxt = LPM_RUN;
      endcase
   end

   assign enter    = (state == LPM_RUN) && (nxt != LPM_RUN);
   assign leave    = (state == LPM_WAIT || state == LPM_STOP) && (nxt == LPM_RUN);
   assign brk_wake = leave && break_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= LPM_RUN;
         imask_clr   <= 1'b0;
         stack_start <= 1'b0;
      end else begin
         state       <= nxt;
         imask_clr   <= enter;
         stack_start <= leave;
      end
   end
endmodule

// File: rtl/lpm_brk_status.sv
module lpm_brk_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_en,
   input  logic wr_data,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flag <= 1'b0;
      else if (set_i)            flag <= 1'b1;
      else if (wr_en && !wr_data) flag <= 1'b0;
   end
endmodule

// File: rtl/lpm_wake_ctrl.sv
module lpm_wake_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned      N_IRQ            = 8,
   parameter logic [N_IRQ-1:0] STOP_WAKE_MASK   = 8'h01,
   parameter bit               COP_RUNS_IN_STOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wait_req,
   input  logic             stop_req,
   input  logic [N_IRQ-1:0] irq_pend,
   input  logic [N_IRQ-1:0] irq_en,
   input  logic             break_req,
   input  logic             cop_disable,
   input  logic             stat_wr_en,
   input  logic             stat_wr_data,
   output logic             cpu_clk_en,
   output logic             per_clk_en,
   output logic             imask_clr,
   output logic             stack_start,
   output logic             brk_stopwait,
   output logic             cop_en
);
   initial begin
      if (N_IRQ < 1 || N_IRQ > 64)
         $error("lpm_wake_ctrl: N_IRQ must lie in 1..64");
   end

   logic       wake_wait;
   logic       wake_stop;
   logic       brk_wake;
   lpm_state_t state;

   lpm_wake_detect #(.N_IRQ(N_IRQ), .STOP_WAKE_MASK(STOP_WAKE_MASK)) u_detect (
      .irq_pend  (irq_pend),
      .irq_en    (irq_en),
      .wake_wait (wake_wait),
      .wake_stop (wake_stop)
   );

   lpm_seq u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .wait_req    (wait_req),
      .stop_req    (stop_req),
      .wake_wait   (wake_wait),
      .wake_stop   (wake_stop),
      .break_req   (break_req),
      .state       (state),
      .imask_clr   (imask_clr),
      .stack_start (stack_start),
      .brk_wake    (brk_wake)
   );

   lpm_brk_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (brk_wake),
      .wr_en   (stat_wr_en),
      .wr_data (stat_wr_data),
      .flag    (brk_stopwait)
   );

   assign cpu_clk_en = (state == LPM_RUN);
   assign per_clk_en = (state != LPM_STOP);

   if (COP_RUNS_IN_STOP) begin : g_cop_always
      assign cop_en = !cop_disable;
   end else begin : g_cop_gated
      assign cop_en = !cop_disable && (state != LPM_STOP);
   end
endmodule

// File: rtl/lpm_wake_ctrl_chk.sv
module lpm_wake_ctrl_chk #(
   parameter int unsigned N_IRQ = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wait_req,
   input logic             stop_req,
   input logic [N_IRQ-1:0] irq_pend,
   input logic [N_IRQ-1:0] irq_en,
   input logic             break_req,
   input logic             cop_disable,
   input logic             cpu_clk_en,
   input logic             per_clk_en,
   input logic             imask_clr,
   input logic             stack_start,
   input logic             brk_stopwait,
   input logic             cop_en
);
   assert_imask_asleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      imask_clr |-> !cpu_clk_en);

   assert_imask_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      imask_clr |=> !imask_clr);

   assert_stack_awake_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stack_start |-> (cpu_clk_en && per_clk_en));

   assert_stop_gates_cpu_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !per_clk_en |-> !cpu_clk_en);

   assert_flag_by_break_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_stopwait) |-> stack_start);

   assert_cop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cop_disable || !per_clk_en) |-> !cop_en);

   assert_wait_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_clk_en && wait_req && !stop_req) |=> (!cpu_clk_en && per_clk_en));
endmodule

bind lpm_wake_ctrl lpm_wake_ctrl_chk #(.N_IRQ(N_IRQ)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .wait_req     (wait_req),
   .stop_req     (stop_req),
   .irq_pend     (irq_pend),
   .irq_en       (irq_en),
   .break_req    (break_req),
   .cop_disable  (cop_disable),
   .cpu_clk_en   (cpu_clk_en),
   .per_clk_en   (per_clk_en),
   .imask_clr    (imask_clr),
   .stack_start  (stack_start),
   .brk_stopwait (brk_stopwait),
   .cop_en       (cop_en)
);

// File: tb/lpm_wake_ctrl_tb_top.sv
module lpm_wake_ctrl_tb_top;
   localparam int unsigned NI = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wait_req = 1'b0, stop_req = 1'b0, break_req = 1'b0;
   logic [NI-1:0] irq_pend = '0, irq_en = '0;
   logic          cop_disable = 1'b0, stat_wr_en = 1'b0, stat_wr_data = 1'b0;
   logic          cpu_clk_en, per_clk_en, imask_clr, stack_start, brk_stopwait, cop_en;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   lpm_wake_ctrl #(.N_IRQ(NI), .STOP_WAKE_MASK(4'b0100)) dut_i (
      .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .stop_req(stop_req),
      .irq_pend(irq_pend), .irq_en(irq_en), .break_req(break_req),
      .cop_disable(cop_disable), .stat_wr_en(stat_wr_en), .stat_wr_data(stat_wr_data),
      .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .imask_clr(imask_clr),
      .stack_start(stack_start), .brk_stopwait(brk_stopwait), .cop_en(cop_en)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1", "cpu_clk_en", cpu_clk_en, 1'b1);
      chk("R1", "per_clk_en", per_clk_en, 1'b1);
      chk("R1", "imask_clr", imask_clr, 1'b0);
      chk("R1", "stack_start", stack_start, 1'b0);
      chk("R1", "brk_stopwait", brk_stopwait, 1'b0);
      chk("R10", "cop_en run", cop_en, 1'b1);
   endtask

   task automatic t_wait_irq();
      wait_req = 1'b1; step(); wait_req = 1'b0;
      chk("R2", "cpu off in wait", cpu_clk_en, 1'b0);
      chk("R2", "per on in wait", per_clk_en, 1'b1);
      chk("R4", "imask pulse", imask_clr, 1'b1);
      chk("R10", "cop in wait", cop_en, 1'b1);
      step();
      chk("R4", "imask single", imask_clr, 1'b0);
      chk("R2", "still asleep", cpu_clk_en, 1'b0);
      irq_pend = 4'b0010; irq_en = 4'b0010; step();
      chk("R5", "cpu back", cpu_clk_en, 1'b1);
      chk("R5", "stack strobe", stack_start, 1'b1);
      irq_pend = '0; irq_en = '0; step();
      chk("R5", "stack single", stack_start, 1'b0);
   endtask

   task automatic t_masked();
      wait_req = 1'b1; step(); wait_req = 1'b0;
      irq_pend = 4'b1000; irq_en = 4'b0111; step(); step();
      chk("R6", "masked no wake", cpu_clk_en, 1'b0);
      chk("R6", "no stack", stack_start, 1'b0);
      irq_en = 4'b1000; step();
      chk("R5", "enabled wakes", cpu_clk_en, 1'b1);
      irq_pend = '0; irq_en = '0; step();
   endtask

   task automatic t_stop();
      stop_req = 1'b1; wait_req = 1'b1; step(); stop_req = 1'b0; wait_req = 1'b0;
      chk("R3", "cpu off in stop", cpu_clk_en, 1'b0);
      chk("R3", "per off (stop wins)", per_clk_en, 1'b0);
      chk("R4", "imask on stop", imask_clr, 1'b1);
      chk("R10", "cop off in stop", cop_en, 1'b0);
      irq_pend = 4'b0011; irq_en = 4'b0011; step(); step();
      chk("R7", "unlisted src ignored", per_clk_en, 1'b0);
      irq_pend = 4'b0100; irq_en = 4'b0100; step();
      chk("R7", "listed src wakes", cpu_clk_en, 1'b1);
      chk("R7", "stack on stop wake", stack_start, 1'b1);
      irq_pend = '0; irq_en = '0; step();
   endtask

   task automatic t_break();
      break_req = 1'b1; step(); break_req = 1'b0;
      chk("R8", "run break no flag", brk_stopwait, 1'b0);
      wait_req = 1'b1; step(); wait_req = 1'b0;
      break_req = 1'b1; step(); break_req = 1'b0;
      chk("R8", "break wakes", cpu_clk_en, 1'b1);
      chk("R8", "flag set", brk_stopwait, 1'b1);
      chk("R8", "stack on break", stack_start, 1'b1);
      step();
   endtask

   task automatic t_status();
      stat_wr_en = 1'b1; stat_wr_data = 1'b1; step();
      chk("R9", "write1 keeps", brk_stopwait, 1'b1);
      stat_wr_data = 1'b0; step(); stat_wr_en = 1'b0;
      chk("R9", "write0 clears", brk_stopwait, 1'b0);
      stop_req = 1'b1; step(); stop_req = 1'b0;
      break_req = 1'b1; stat_wr_en = 1'b1; stat_wr_data = 1'b0; step();
      break_req = 1'b0; stat_wr_en = 1'b0;
      chk("R9", "set beats clear", brk_stopwait, 1'b1);
      chk("R8", "break wakes stop", per_clk_en, 1'b1);
      step();
   endtask

   task automatic t_cop();
      cop_disable = 1'b1; #1;
      chk("R10", "disabled run", cop_en, 1'b0);
      wait_req = 1'b1; step(); wait_req = 1'b0;
      chk("R10", "disabled wait", cop_en, 1'b0);
      cop_disable = 1'b0; #1;
      chk("R10", "enabled wait", cop_en, 1'b1);
      irq_pend = 4'b0001; irq_en = 4'b0001; step();
      irq_pend = '0; irq_en = '0; step();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_wait_irq();
      t_masked();
      t_stop();
      t_break();
      t_status();
      t_cop();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule